// File: doc/BRIEF.md
# Scan-Code Keyboard Receive Controller

This block accepts a stream of 8-bit scan codes in the common PC keyboard set, one code per cycle when its valid strobe is high. Each code is sorted into one of two kinds. The shift and command keys are never stored. Pressing one of them loads a single held-modifier register, and releasing any of them clears that register. Every other code is translated through a 128-entry lookup into a native 7-bit key number. Bit 7 of the incoming code, which marks a release, is kept with the key number, and the resulting byte is written into a circular queue.

A processor reads the block over a simple register bus. A 32-bit read at the data offset removes the oldest queued byte. The value returned combines that byte with the modifier bits held at the moment of the read, plus a valid flag. A removed release byte is consumed but reads back as zero. A word read at offset 0 returns a fixed status word, and byte reads at offsets 0 to 2 return fixed identification bytes. Writes have no effect. Every read answers on `rdata` one cycle after its strobe, and `rdata` holds that value until the next read.

Top module: `kbd_scan_rx`

## Requirements
- R1: After reset the queue is empty, no modifier is held and the extended-prefix flag is clear, so a word read at offset 0x8 returns 0.
- R2: A code that is not a modifier press or release is queued as lookup[code[6:0]] | code[7]. Lookup examples: 0x01 gives 0x49, 0x05 gives 0x4D, 0x1C gives 0x2A, 0x39 gives 0x38, and an unmapped index such as 0x50 gives 0x00.
- R3: A word read (bus_size 2'b10) at address low nibble 0x8 with the queue non-empty pops the oldest entry in arrival order. It returns 0x1000_8000 | held_mod | entry on rdata in the cycle after the strobe.
- R4: A popped entry with bit 7 set reads back as 0 and is still removed.
- R5: Code 0x2A holds left shift (0x0200). Code 0x36 holds right shift (0x0400) and clears the prefix flag. Code 0x1D holds left command (0x0800), or right command (0x1000) when the prefix flag is set, and in that case clears the flag. A later press replaces the held value. None of these codes is queued. The held value is applied when an entry is popped, not when it is queued.
- R6: Codes 0xAA, 0x9D and 0xB6 clear the held modifier to 0 and are not queued.
- R7: Code 0xE0 sets the prefix flag and is also queued, as entry 0x80.
- R8: A word read at offset 0x8 with the queue empty returns 0 and changes no state.
- R9: The queue holds DEPTH (default 256) entries. A code that arrives while the queue is full is dropped, unless a pop occurs in the same cycle.
- R10: A push and a pop in the same cycle both take effect and leave the occupancy unchanged. The popped value is the old head.
- R11: A word read at offset 0x0 returns 0xA0F0_9300. Byte reads (bus_size 2'b00) at address low bits 0, 1 and 2 return 0xA0, 0xF0 and 0x13 in rdata[7:0]. Every other read (byte offset 3, halfword 2'b01, size 2'b11, other word offsets) returns 0 and pops nothing.
- R12: A bus write, including one at offset 0x8, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_valid | input | 1 | Scan code strobe |
| code_in | input | 8 | Scan code |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (no effect) |
| bus_addr | input | ADDR_W | Byte address within the block |
| bus_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| bus_wdata | input | 32 | Write data (no effect) |
| rdata | output | 32 | Registered read response |

## Verification
Two things can land in the same cycle: a scan code arriving and a data-offset read that pops the queue. The bench drives both strobes on the same falling edge in two situations. In the first the queue is partly filled. In the second it holds exactly DEPTH entries, where the incoming code must still be accepted. In each case the bench checks that the response is the old head. It then drains the queue and compares every later entry, including the one pushed alongside the pop, against the expected order, and finally checks for an empty read.

// File: rtl/kbd_pkg.sv
// Package: shared encodings and constants for the scan-code receive controller.
// Assumes the bus carries a 2-bit access size and a byte address.
package kbd_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } bus_size_e;

    localparam logic [15:0] HM_LSHIFT = 16'h0200;
    localparam logic [15:0] HM_RSHIFT = 16'h0400;
    localparam logic [15:0] HM_LCMD   = 16'h0800;
    localparam logic [15:0] HM_RCMD   = 16'h1000;

    localparam logic [7:0] SC_LSHIFT = 8'h2A;
    localparam logic [7:0] SC_RSHIFT = 8'h36;
    localparam logic [7:0] SC_CMD    = 8'h1D;
    localparam logic [7:0] SC_PREFIX = 8'hE0;
    localparam logic [7:0] SC_BREAK  = 8'h80;

    localparam logic [3:0]  OFS_STATUS = 4'h0;
    localparam logic [3:0]  OFS_DATA   = 4'h8;
    localparam logic [31:0] STATUS_WORD = 32'hA0F0_9300;
    localparam logic [31:0] POP_TAG     = 32'h1000_8000;

endpackage

// File: rtl/kbd_xlate.sv
// Module: kbd_xlate
// Pure combinational lookup from a 7-bit scan index to a native key number.
// Assumes that indices not listed below have no native key and map to 0.
module kbd_xlate (
    input  logic [6:0] idx,
    output logic [6:0] key
);
    // Lookup: index to native key number
    always_comb begin
        unique case (idx)
            7'h01: key = 7'h49;  7'h02: key = 7'h4A;  7'h03: key = 7'h4B;
            7'h04: key = 7'h4C;  7'h05: key = 7'h4D;  7'h06: key = 7'h50;
            7'h07: key = 7'h4F;  7'h08: key = 7'h4E;  7'h09: key = 7'h1E;
            7'h0A: key = 7'h1F;  7'h0B: key = 7'h20;  7'h0C: key = 7'h1D;
            7'h0D: key = 7'h1C;  7'h0E: key = 7'h1B;  7'h10: key = 7'h42;
            7'h11: key = 7'h43;  7'h12: key = 7'h44;  7'h13: key = 7'h45;
            7'h14: key = 7'h48;  7'h15: key = 7'h47;  7'h16: key = 7'h46;
            7'h17: key = 7'h06;  7'h18: key = 7'h07;  7'h19: key = 7'h08;
            7'h1C: key = 7'h2A;  7'h1E: key = 7'h39;  7'h1F: key = 7'h3A;
            7'h20: key = 7'h3B;  7'h21: key = 7'h3C;  7'h22: key = 7'h3D;
            7'h23: key = 7'h40;  7'h24: key = 7'h3F;  7'h25: key = 7'h3E;
            7'h26: key = 7'h2D;  7'h27: key = 7'h2C;  7'h28: key = 7'h2B;
            7'h29: key = 7'h26;  7'h2C: key = 7'h31;  7'h2D: key = 7'h32;
            7'h2E: key = 7'h33;  7'h2F: key = 7'h34;  7'h30: key = 7'h35;
            7'h31: key = 7'h37;  7'h32: key = 7'h36;  7'h33: key = 7'h2E;
            7'h34: key = 7'h2F;  7'h35: key = 7'h30;  7'h39: key = 7'h38;
            default: key = 7'h00;
        endcase
    end
endmodule

// File: rtl/kbd_mod_track.sv
// Module: kbd_mod_track
// Classifies each incoming scan code. Modifier presses and releases update
// the held-modifier register and are not forwarded. Every other code is
// forwarded as a push request. Assumes at most one code per cycle.
module kbd_mod_track
    import kbd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        code_valid,
    input  logic [7:0]  code_in,
    output logic [15:0] held_mod,
    output logic        push_req
);
    logic prefix_q;
    logic is_press;
    logic is_break;

    // Decode: which modifier class the current code belongs to
    always_comb begin
        is_press = (code_in == SC_LSHIFT) || (code_in == SC_RSHIFT) ||
                   (code_in == SC_CMD);
        is_break = (code_in == (SC_LSHIFT | SC_BREAK)) ||
                   (code_in == (SC_RSHIFT | SC_BREAK)) ||
                   (code_in == (SC_CMD | SC_BREAK));
        push_req = code_valid && !is_press && !is_break;
    end

    // State: held modifier and extended-prefix flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_mod <= '0;
            prefix_q <= 1'b0;
        end else if (code_valid) begin
            if (code_in == SC_PREFIX) begin
                prefix_q <= 1'b1;
            end
            if (code_in == SC_LSHIFT) begin
                held_mod <= HM_LSHIFT;
            end else if (code_in == SC_RSHIFT) begin
                held_mod <= HM_RSHIFT;
                prefix_q <= 1'b0;
            end else if (code_in == SC_CMD) begin
                if (prefix_q) begin
                    held_mod <= HM_RCMD;
                    prefix_q <= 1'b0;
                end else begin
                    held_mod <= HM_LCMD;
                end
            end else if (is_break) begin
                held_mod <= '0;
            end
        end
    end
endmodule

// File: rtl/kbd_ring.sv
// Module: kbd_ring
// Circular queue with separate read and write pointers and an occupancy
// count. A push while full is accepted only if a pop happens in the same
// cycle. The head is read combinationally, so a pop sees the old head.
module kbd_ring #(
    parameter int DEPTH  = 256,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [DATA_W-1:0]         push_data,
    input  logic                      pop_req,
    output logic [DATA_W-1:0]         head,
    output logic                      empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    logic              full;
    logic              do_pop;
    logic              do_push;

    // Flags: occupancy state and accepted operations
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        do_pop  = pop_req && !empty;
        do_push = push && (!full || do_pop);
        head    = store[rptr];
    end

    // Storage: write the accepted entry
    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wptr] <= push_data;
        end
    end

    // Pointers and count: advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            end
            if (do_push && !do_pop) begin
                count <= count + 1'b1;
            end else if (do_pop && !do_push) begin
                count <= count - 1'b1;
            end
        end
    end
endmodule

// File: rtl/kbd_bus_read.sv
// Module: kbd_bus_read
// Decodes a bus read into a response word and a pop request. The logic is
// combinational, and the top registers the response. Assumes the address
// low nibble is enough to select a register.
module kbd_bus_read
    import kbd_pkg::*;
(
    input  logic        rd,
    input  logic [1:0]  size,
    input  logic [3:0]  addr_lo,
    input  logic [7:0]  head,
    input  logic        empty,
    input  logic [15:0] held_mod,
    output logic        pop_req,
    output logic [31:0] resp
);
    bus_size_e   sz;
    logic [15:0] merged;

    // Decode: select response by access size and offset
    always_comb begin
        sz      = bus_size_e'(size);
        merged  = held_mod | {8'h00, head};
        pop_req = 1'b0;
        resp    = '0;
        if (rd) begin
            unique case (sz)
                SZ_BYTE: begin
                    unique case (addr_lo[1:0])
                        2'd0:    resp = {24'h0, STATUS_WORD[31:24]};
                        2'd1:    resp = {24'h0, STATUS_WORD[23:16]};
                        2'd2:    resp = 32'h0000_0013;
                        default: resp = '0;
                    endcase
                end
                SZ_WORD: begin
                    if (addr_lo == OFS_STATUS) begin
                        resp = STATUS_WORD;
                    end else if (addr_lo == OFS_DATA && !empty) begin
                        pop_req = 1'b1;
                        resp    = merged[7] ? '0 : (POP_TAG | {16'h0, merged});
                    end
                end
                default: resp = '0;
            endcase
        end
    end
endmodule

// File: rtl/kbd_scan_rx.sv
// Module: kbd_scan_rx (top)
// Scan-code receive controller. Translates and queues scan codes, holds
// the modifier state, and answers bus reads with a registered response one
// cycle after the strobe. Writes are ignored. Assumes ADDR_W > 4.
module kbd_scan_rx #(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              code_valid,
    input  logic [7:0]        code_in,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       rdata
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [15:0]      held_mod;
    logic             push_req;
    logic [6:0]       key;
    logic [7:0]       entry;
    logic             pop_req;
    logic [7:0]       head;
    logic             q_empty;
    logic [CNT_W-1:0] q_count;
    logic [31:0]      resp;
    logic [3:0]       addr_lo;
    logic             unused_bus;

    // Glue: form the queued byte and the address nibble
    always_comb begin
        entry      = {code_in[7], key};
        addr_lo    = bus_addr[3:0];
        unused_bus = ^{bus_wr, bus_wdata, bus_addr[ADDR_W-1:4]};
    end

    kbd_mod_track u_mod (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_valid (code_valid),
        .code_in    (code_in),
        .held_mod   (held_mod),
        .push_req   (push_req)
    );

    kbd_xlate u_xlate (
        .idx (code_in[6:0]),
        .key (key)
    );

    kbd_ring #(.DEPTH(DEPTH), .DATA_W(8)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_req),
        .push_data (entry),
        .pop_req   (pop_req),
        .head      (head),
        .empty     (q_empty),
        .count     (q_count)
    );

    kbd_bus_read u_rd (
        .rd       (bus_rd),
        .size     (bus_size),
        .addr_lo  (addr_lo),
        .head     (head),
        .empty    (q_empty),
        .held_mod (held_mod),
        .pop_req  (pop_req),
        .resp     (resp)
    );

    // Response register: capture the read result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (bus_rd) begin
            rdata <= resp;
        end
    end
endmodule

// File: rtl/kbd_scan_rx_chk.sv
// Module: kbd_scan_rx_chk
// Property checker bound to kbd_scan_rx. Observes ports, the queue count
// and the held modifier.
module kbd_scan_rx_chk #(
    parameter int DEPTH = 256,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             code_valid,
    input logic [7:0]       code_in,
    input logic             bus_rd,
    input logic [3:0]       addr_lo,
    input logic [1:0]       bus_size,
    input logic [31:0]      rdata,
    input logic [CNT_W-1:0] q_count,
    input logic [15:0]      held_mod
);
    logic data_rd;
    logic stat_rd;
    assign data_rd = bus_rd && bus_size == 2'b10 && addr_lo == 4'h8;
    assign stat_rd = bus_rd && bus_size == 2'b10 && addr_lo == 4'h0;

    a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        data_rd && q_count == '0 && !code_valid |=> rdata == '0 && q_count == '0);

    a_r11_status_word: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> rdata == 32'hA0F0_9300);

    a_r5_press_not_queued: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid && !bus_rd &&
        (code_in == 8'h2A || code_in == 8'h36 || code_in == 8'h1D)
        |=> q_count == $past(q_count));

    a_r5_single_mod: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(held_mod));

    a_r6_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid && (code_in == 8'hAA || code_in == 8'h9D || code_in == 8'hB6)
        |=> held_mod == '0);

    a_r9_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        q_count == CNT_W'(DEPTH) && code_valid && !bus_rd |=> q_count == CNT_W'(DEPTH));

    a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CNT_W'(DEPTH));

    a_r10_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid && code_in == 8'h04 && data_rd && q_count != '0
        |=> q_count == $past(q_count));
endmodule

bind kbd_scan_rx kbd_scan_rx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_valid (code_valid),
    .code_in    (code_in),
    .bus_rd     (bus_rd),
    .addr_lo    (addr_lo),
    .bus_size   (bus_size),
    .rdata      (rdata),
    .q_count    (q_count),
    .held_mod   (held_mod)
);

// File: tb/kbd_scan_rx_tb.sv
`timescale 1ns/1ps
module kbd_scan_rx_tb;
    localparam int DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        code_valid = 1'b0;
    logic [7:0]  code_in = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] d;

    always #2.5 clk = ~clk;

    kbd_scan_rx #(.DEPTH(DEPTH), .ADDR_W(12)) u_dut (
        .clk(clk), .rst_n(rst_n), .code_valid(code_valid), .code_in(code_in),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .rdata(rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic send(input logic [7:0] c);
        code_valid = 1'b1; code_in = c;
        @(negedge clk);
        code_valid = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sz, input logic [11:0] a, output logic [31:0] v);
        bus_rd = 1'b1; bus_size = sz; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = rdata;
    endtask

    task automatic pop_expect(input string tag, input logic [31:0] exp);
        logic [31:0] v;
        rd(2'b10, 12'h008, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset;
        pop_expect("R1 empty after reset", 32'h0);
    endtask

    task automatic t_translate;
        send(8'h01); send(8'h1C); send(8'h39); send(8'h05); send(8'h50);
        pop_expect("R2/R3 0x01", 32'h1000_8049);
        pop_expect("R2/R3 0x1C", 32'h1000_802A);
        pop_expect("R2/R3 0x39", 32'h1000_8038);
        pop_expect("R2/R3 0x05", 32'h1000_804D);
        pop_expect("R2 unmapped", 32'h1000_8000);
        pop_expect("R8 drained", 32'h0);
    endtask

    task automatic t_release;
        send(8'h81); send(8'h02);
        pop_expect("R4 release entry", 32'h0);
        pop_expect("R4 consumed", 32'h1000_804A);
        pop_expect("R8 empty again", 32'h0);
    endtask

    task automatic t_modifiers;
        send(8'h2A);
        pop_expect("R5 press not queued", 32'h0);
        send(8'h10);
        pop_expect("R5 left shift", 32'h1000_8242);
        send(8'h36); send(8'h11);
        pop_expect("R5 right shift", 32'h1000_8443);
        send(8'hB6); send(8'h12); send(8'h1D);
        pop_expect("R5 applied at pop", 32'h1000_8844);
        send(8'h9D); send(8'hE0); send(8'h1D); send(8'h13);
        pop_expect("R7 prefix queued", 32'h0);
        pop_expect("R5 right command", 32'h1000_9045);
        send(8'hAA);
        pop_expect("R6 release not queued", 32'h0);
        send(8'h1D); send(8'h14);
        pop_expect("R5 prefix cleared", 32'h1000_8848);
        send(8'hE0); send(8'h36); send(8'h1D); send(8'h15);
        pop_expect("R7 prefix entry", 32'h0);
        pop_expect("R5 0x36 clears prefix", 32'h1000_8847);
        send(8'hB6); send(8'h16);
        pop_expect("R6 modifier cleared", 32'h1000_8046);
    endtask

    task automatic t_fixed_reads;
        logic [31:0] v;
        send(8'h01);
        rd(2'b10, 12'h000, v); check("R11 status word", v, 32'hA0F0_9300);
        rd(2'b00, 12'h000, v); check("R11 byte 0", v, 32'h0000_00A0);
        rd(2'b00, 12'h001, v); check("R11 byte 1", v, 32'h0000_00F0);
        rd(2'b00, 12'h002, v); check("R11 byte 2", v, 32'h0000_0013);
        rd(2'b00, 12'h003, v); check("R11 byte 3", v, 32'h0);
        rd(2'b01, 12'h008, v); check("R11 halfword", v, 32'h0);
        rd(2'b10, 12'h004, v); check("R11 word 4", v, 32'h0);
        rd(2'b11, 12'h008, v); check("R11 reserved size", v, 32'h0);
        pop_expect("R11 no pop by other reads", 32'h1000_8049);
    endtask

    task automatic t_writes;
        send(8'h02);
        bus_wr = 1'b1; bus_size = 2'b10; bus_addr = 12'h008; bus_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        bus_wr = 1'b0;
        pop_expect("R12 write ignored", 32'h1000_804A);
        pop_expect("R12 nothing added", 32'h0);
    endtask

    task automatic fill(input logic [7:0] c);
        for (int i = 0; i < DEPTH; i++) send(c);
    endtask

    task automatic t_full_drop;
        int bad;
        bad = 0;
        fill(8'h03);
        send(8'h04);
        for (int i = 0; i < DEPTH; i++) begin
            rd(2'b10, 12'h008, d);
            if (d !== 32'h1000_804B) bad++;
        end
        check("R9 full contents", bad, 0);
        pop_expect("R9 extra dropped", 32'h0);
    endtask

    task automatic push_and_pop(input logic [7:0] c, output logic [31:0] v);
        code_valid = 1'b1; code_in = c;
        bus_rd = 1'b1; bus_size = 2'b10; bus_addr = 12'h008;
        @(negedge clk);
        code_valid = 1'b0; bus_rd = 1'b0;
        v = rdata;
    endtask

    task automatic t_same_cycle;
        int bad;
        logic [31:0] v;
        send(8'h05);
        push_and_pop(8'h06, v);
        check("R10 old head", v, 32'h1000_804D);
        pop_expect("R10 pushed entry", 32'h1000_8050);
        pop_expect("R10 count kept", 32'h0);
        fill(8'h03);
        push_and_pop(8'h04, v);
        check("R9/R10 pop at full", v, 32'h1000_804B);
        bad = 0;
        for (int i = 0; i < DEPTH - 1; i++) begin
            rd(2'b10, 12'h008, d);
            if (d !== 32'h1000_804B) bad++;
        end
        check("R9 remaining", bad, 0);
        pop_expect("R9 accepted at full", 32'h1000_804C);
        pop_expect("R10 empty after drain", 32'h0);
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_translate();
        t_release();
        t_modifiers();
        t_fixed_reads();
        t_writes();
        t_full_drop();
        t_same_cycle();
        finish_run();
    end
endmodule